// File: doc/BRIEF.md
# Nonvolatile SRAM store controller

This block sits in front of a byte-wide static RAM that has a shadow nonvolatile copy. It turns active-low chip, output and write enables into single-clock read and write cycles on the SRAM. It also runs two bulk operations. A STORE copies the whole SRAM into the nonvolatile shadow. A RECALL copies the whole shadow back into the SRAM. Each operation takes a fixed, parameterised number of clock cycles. While one is running, `op_busy` is high and the block ignores host reads and writes.

There are three ways to start a STORE: a software request pulse, a power-fail flag, or another agent pulling the shared store-busy line low. A STORE started by the line or by power-fail runs only if a write has landed since the last STORE or RECALL. A software STORE always runs. While a STORE runs, the block pulls the store-busy line low itself, so other agents on that line see it as busy. The pad supplies a weak pull-up, so an undriven line reads high. Once after every reset the block runs a RECALL, which restores the SRAM from the shadow. A saturating counter records how many STOREs have run, for wear tracking.

Top module: `nvs_ctrl`

## Requirements
- R1: A read happens when `ce_n`=0, `oe_n`=0, `we_n`=1 and `stbusy_n`=1 with no operation running. In that case `data_oe`=1 and `data_out` shows the addressed byte. In every other case `data_oe`=0 and `data_out`=0.
- R2: A write happens on the clock edge when `ce_n`=0, `we_n`=0 and `stbusy_n`=1 with no operation running. `oe_n`=0 does not block the write. `data_oe` stays 0 whenever `we_n`=0. With `ce_n`=1, `we_n`=0 writes nothing.
- R3: While the store-busy line reads low, no read or write takes place.
- R4: A STORE keeps `op_busy`=1 for exactly STORE_CYCLES cycles and a RECALL for exactly RECALL_CYCLES cycles. While `op_busy`=1, reads and writes are ignored and the SRAM keeps its contents.
- R5: When the line reads low in idle, a STORE starts only if a write has happened since the last STORE or RECALL. `stbusy_pull` is 1 while any STORE runs.
- R6: When `pwr_fail`=1 in idle, a STORE starts only if a write has happened since the last STORE or RECALL.
- R7: When `sw_store`=1 in idle, a STORE always starts.
- R8: Requests that arrive in the same cycle start a single STORE. Requests made while `op_busy`=1 are dropped and do not run later.
- R9: Reset sets `op_busy`=1, `data_oe`=0, `stbusy_pull`=0, `store_count`=0 and `wear_limit`=0. After reset a RECALL runs once. It loads the SRAM from the nonvolatile copy, which keeps its contents across reset, and it clears the record of writes.
- R10: `store_count` counts STOREs that actually run and saturates at ENDURANCE. `wear_limit`=1 exactly when the count equals ENDURANCE.
- R11: The address is ADDR_W bits wide. Only the low DEPTH_W bits select a byte, so addresses that differ only in higher bits map to the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| data_in | input | DATA_W | Write data |
| data_out | output | DATA_W | Read data, zero when not reading |
| data_oe | output | 1 | Drive enable for the data pads |
| stbusy_n | input | 1 | Store-busy line as seen at the pad (pulled up) |
| stbusy_pull | output | 1 | Pull the store-busy line low |
| sw_store | input | 1 | Software STORE request, one pulse per request |
| pwr_fail | input | 1 | Power-fail indication |
| op_busy | output | 1 | STORE or RECALL in progress |
| store_count | output | CNT_W | Saturating count of STOREs that have run |
| wear_limit | output | 1 | Count has reached ENDURANCE |

## Verification
Some properties are checked on every cycle:
- no data drive and no write while an operation is running;
- no data drive while write enable is low;
- no STORE begins without a software request or a pending write;
- the record of writes stays clear during an operation;
- a saturated counter stays put.

Other behaviour needs the bench's scenarios:
- exact busy lengths;
- which trigger combinations start a STORE and which are dropped;
- merging of simultaneous requests;
- contents surviving a reset through the nonvolatile copy;
- address aliasing.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_STORE  = 2'd1,
        OP_RECALL = 2'd2
    } op_e;
endpackage

// File: rtl/nvs_access_decode.sv
module nvs_access_decode (
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic stbusy_n,
    input  logic inhibit,
    output logic rd_en,
    output logic wr_en
);
    logic host_ok;

    always_comb begin
        host_ok = !ce_n && stbusy_n && !inhibit;
        rd_en   = host_ok && !oe_n && we_n;
        wr_en   = host_ok && !we_n;
    end
endmodule

// File: rtl/nvs_cell_array.sv
module nvs_cell_array #(
    parameter int DEPTH_W = 6,
    parameter int DATA_W  = 8,
    localparam int DEPTH  = 1 << DEPTH_W
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [DEPTH_W-1:0] idx,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               do_store,
    input  logic               do_recall
);
    logic [DATA_W-1:0] sram_q [DEPTH];
    logic [DATA_W-1:0] nv_q   [DEPTH];

    // Bulk transfer: every word moves in the same edge.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (do_recall) begin
                sram_q[i] <= nv_q[i];
            end else if (wr_en && idx == DEPTH_W'(i)) begin
                sram_q[i] <= wr_data;
            end
            if (do_store) begin
                nv_q[i] <= sram_q[i];
            end
        end
    end

    assign rd_data = sram_q[idx];
endmodule

// File: rtl/nvs_op_ctrl.sv
module nvs_op_ctrl
    import nvs_pkg::*;
#(
    parameter int STORE_CYCLES  = 8,
    parameter int RECALL_CYCLES = 4,
    parameter int ENDURANCE     = 200000,
    localparam int TMAX   = (STORE_CYCLES > RECALL_CYCLES) ? STORE_CYCLES : RECALL_CYCLES,
    localparam int TIMER_W = $clog2(TMAX + 1),
    localparam int CNT_W  = $clog2(ENDURANCE + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             sw_store,
    input  logic             pwr_fail,
    input  logic             stbusy_n,
    output logic             busy,
    output logic             pull_lo,
    output logic             do_store,
    output logic             do_recall,
    output logic [CNT_W-1:0] store_count,
    output logic             wear_limit
);
    typedef struct packed {
        op_e                op;
        logic [TIMER_W-1:0] timer;
        logic               dirty;
        logic [CNT_W-1:0]   stores;
    } st_t;

    st_t st_d, st_q;
    logic want_store;

    always_comb begin
        st_d       = st_q;
        want_store = sw_store || (st_q.dirty && (pwr_fail || !stbusy_n));
        do_store   = (st_q.op == OP_STORE)  && (st_q.timer == '0);
        do_recall  = (st_q.op == OP_RECALL) && (st_q.timer == '0);

        unique case (st_q.op)
            OP_IDLE: begin
                if (wr_en) st_d.dirty = 1'b1;
                if (want_store) begin
                    st_d.op    = OP_STORE;
                    st_d.timer = TIMER_W'(STORE_CYCLES - 1);
                    st_d.dirty = 1'b0;
                    if (st_q.stores != CNT_W'(ENDURANCE)) begin
                        st_d.stores = st_q.stores + 1'b1;
                    end
                end
            end
            OP_STORE, OP_RECALL: begin
                if (st_q.timer == '0) st_d.op = OP_IDLE;
                else                  st_d.timer = st_q.timer - 1'b1;
            end
            default: st_d.op = OP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.op     <= OP_RECALL;
            st_q.timer  <= TIMER_W'(RECALL_CYCLES - 1);
            st_q.dirty  <= 1'b0;
            st_q.stores <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy        = (st_q.op != OP_IDLE);
    assign pull_lo     = (st_q.op == OP_STORE);
    assign store_count = st_q.stores;
    assign wear_limit  = (st_q.stores == CNT_W'(ENDURANCE));

    // R7 / R5 / R6: a STORE only begins on a software request or a pending write
    p_store_cause_r7: assert property (@(posedge clk) disable iff (rst)
        (st_q.op == OP_STORE && $past(st_q.op) == OP_IDLE) |-> ($past(sw_store) || $past(st_q.dirty)));

    // R4: the write record cannot change while an operation holds the array
    p_clean_in_op_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q.op != OP_IDLE) |-> !st_q.dirty);

    // R10: once saturated the counter does not move
    p_wear_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (st_q.stores == CNT_W'(ENDURANCE)) |=> (st_q.stores == CNT_W'(ENDURANCE)));
endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl #(
    parameter int ADDR_W        = 17,
    parameter int DATA_W        = 8,
    parameter int DEPTH_W       = 6,
    parameter int STORE_CYCLES  = 8,
    parameter int RECALL_CYCLES = 4,
    parameter int ENDURANCE     = 200000,
    localparam int CNT_W        = $clog2(ENDURANCE + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    input  logic              stbusy_n,
    output logic              stbusy_pull,
    input  logic              sw_store,
    input  logic              pwr_fail,
    output logic              op_busy,
    output logic [CNT_W-1:0]  store_count,
    output logic              wear_limit
);
    logic              rd_en, wr_en, do_store, do_recall;
    logic [DATA_W-1:0] rd_word;
    logic              addr_unused;

    assign addr_unused = ^addr[ADDR_W-1:DEPTH_W];

    nvs_access_decode u_dec (
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .stbusy_n (stbusy_n),
        .inhibit  (op_busy),
        .rd_en    (rd_en),
        .wr_en    (wr_en)
    );

    nvs_op_ctrl #(
        .STORE_CYCLES  (STORE_CYCLES),
        .RECALL_CYCLES (RECALL_CYCLES),
        .ENDURANCE     (ENDURANCE)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .sw_store    (sw_store),
        .pwr_fail    (pwr_fail),
        .stbusy_n    (stbusy_n),
        .busy        (op_busy),
        .pull_lo     (stbusy_pull),
        .do_store    (do_store),
        .do_recall   (do_recall),
        .store_count (store_count),
        .wear_limit  (wear_limit)
    );

    nvs_cell_array #(
        .DEPTH_W (DEPTH_W),
        .DATA_W  (DATA_W)
    ) u_arr (
        .clk       (clk),
        .wr_en     (wr_en),
        .idx       (addr[DEPTH_W-1:0]),
        .wr_data   (data_in),
        .rd_data   (rd_word),
        .do_store  (do_store),
        .do_recall (do_recall)
    );

    assign data_oe  = rd_en;
    assign data_out = rd_en ? rd_word : '0;

    // R4: no pad drive and no write while an operation runs
    p_no_access_busy_r4: assert property (@(posedge clk) disable iff (rst)
        op_busy |-> (!data_oe && !wr_en));

    // R2: data pads released whenever write enable is low
    p_oe_off_write_r2: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> !data_oe);
endmodule

// File: tb/tb_nvs_ctrl.sv
`timescale 1ns/1ps
module tb_nvs_ctrl;
    localparam int ADDR_W = 17;
    localparam int DATA_W = 8;
    localparam int DEPTH_W = 4;
    localparam int SC = 4;
    localparam int RC = 3;
    localparam int END_LIM = 5;
    localparam int CNT_W = $clog2(END_LIM + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] data_in = '0;
    logic [DATA_W-1:0] data_out;
    logic data_oe, stbusy_pull, op_busy, wear_limit;
    logic sw_store = 1'b0, pwr_fail = 1'b0, tb_pull = 1'b0;
    logic [CNT_W-1:0] store_count;
    wire  stbusy_n = !(tb_pull || stbusy_pull);

    int checks = 0;
    int fails  = 0;
    int exp_cnt = 0;

    always #2.5 clk = ~clk;

    nvs_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH_W(DEPTH_W),
        .STORE_CYCLES(SC), .RECALL_CYCLES(RC), .ENDURANCE(END_LIM)
    ) dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
        .stbusy_n(stbusy_n), .stbusy_pull(stbusy_pull), .sw_store(sw_store),
        .pwr_fail(pwr_fail), .op_busy(op_busy), .store_count(store_count),
        .wear_limit(wear_limit)
    );

    // {ce_n,oe_n,we_n}, addr, data_in, expected data_oe, expected data_out
    localparam int NV = 9;
    localparam logic [36:0] VEC [NV] = '{
        {3'b010, 17'd1,    8'h5A, 1'b0, 8'h00},  // R2 write
        {3'b000, 17'd2,    8'hC3, 1'b0, 8'h00},  // R2 write with oe low
        {3'b001, 17'd1,    8'h00, 1'b1, 8'h5A},  // R1 read
        {3'b001, 17'd2,    8'h00, 1'b1, 8'hC3},  // R1 read
        {3'b101, 17'd1,    8'h00, 1'b0, 8'h00},  // R1 deselected
        {3'b011, 17'd1,    8'h00, 1'b0, 8'h00},  // R1 output disabled
        {3'b001, 17'h10001,8'h00, 1'b1, 8'h5A},  // R11 alias of byte 1
        {3'b110, 17'd1,    8'hFF, 1'b0, 8'h00},  // R2 we low, chip off
        {3'b001, 17'd1,    8'h00, 1'b1, 8'h5A}   // R2 no write happened
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic host_idle();
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; data_in = d;
        @(negedge clk);
        host_idle();
    endtask

    task automatic rd_chk(input string req, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
        #1;
        chk(req, {31'd0, data_oe}, 32'd1);
        chk(req, {24'd0, data_out}, {24'd0, e});
        host_idle();
    endtask

    // Hold requests for one cycle, then count busy cycles.
    task automatic run_op(input logic sw, input logic pf, input logic hw,
                          output int n, output bit pulled);
        @(negedge clk);
        sw_store = sw; pwr_fail = pf; tb_pull = hw;
        @(negedge clk);
        sw_store = 1'b0; pwr_fail = 1'b0; tb_pull = 1'b0;
        n = 0; pulled = 1'b0;
        while (op_busy && n < 40) begin
            n++;
            if (stbusy_pull) pulled = 1'b1;
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        int n;
        bit pl;

        // R9 reset state
        repeat (2) @(negedge clk);
        chk("R9 busy in reset", {31'd0, op_busy}, 32'd1);
        chk("R9 oe in reset", {31'd0, data_oe}, 32'd0);
        chk("R9 pull in reset", {31'd0, stbusy_pull}, 32'd0);
        chk("R9 count in reset", {29'd0, store_count}, 32'd0);
        chk("R9 wear in reset", {31'd0, wear_limit}, 32'd0);
        rst = 1'b0;
        n = 0;
        while (op_busy && n < 40) begin n++; @(negedge clk); end
        chk("R9 R4 recall length", n, RC);

        // R1 R2 R11 vector table
        for (int i = 0; i < NV; i++) begin
            ce_n = VEC[i][36]; oe_n = VEC[i][35]; we_n = VEC[i][34];
            addr = VEC[i][33:17]; data_in = VEC[i][16:9];
            #1;
            chk("R1/R2/R11 vec oe", {31'd0, data_oe}, {31'd0, VEC[i][8]});
            chk("R1/R2/R11 vec data", {24'd0, data_out}, {24'd0, VEC[i][7:0]});
            @(negedge clk);
        end
        host_idle();

        // R5 line store with pending write
        run_op(1'b0, 1'b0, 1'b1, n, pl);
        exp_cnt++;
        chk("R5 line store length", n, SC);
        chk("R5 pull during store", {31'd0, pl}, 32'd1);
        chk("R10 count", {29'd0, store_count}, exp_cnt);
        // R5 clean: skipped
        run_op(1'b0, 1'b0, 1'b1, n, pl);
        chk("R5 clean line store skipped", n, 0);

        // R3 line low blocks reads (clean, so no store starts)
        @(negedge clk);
        tb_pull = 1'b1; ce_n = 1'b0; oe_n = 1'b0; addr = 17'd1;
        #1;
        chk("R3 read blocked by line", {31'd0, data_oe}, 32'd0);
        @(negedge clk);
        chk("R3 no store while clean", {31'd0, op_busy}, 32'd0);
        tb_pull = 1'b0; host_idle();

        // R6 power-fail
        run_op(1'b0, 1'b1, 1'b0, n, pl);
        chk("R6 clean pf skipped", n, 0);
        wr(17'd4, 8'h44);
        run_op(1'b0, 1'b1, 1'b0, n, pl);
        exp_cnt++;
        chk("R6 pf store length", n, SC);

        // R7 software store while clean
        run_op(1'b1, 1'b0, 1'b0, n, pl);
        exp_cnt++;
        chk("R7 sw store length", n, SC);
        chk("R10 count", {29'd0, store_count}, exp_cnt);

        // R8 merged requests
        wr(17'd4, 8'h45);
        run_op(1'b1, 1'b1, 1'b1, n, pl);
        exp_cnt++;
        chk("R8 merged length", n, SC);
        chk("R8 merged count", {29'd0, store_count}, exp_cnt);
        repeat (3) @(negedge clk);
        chk("R8 no follow-on op", {31'd0, op_busy}, 32'd0);

        // R8 request during busy dropped; R10 reaches limit
        @(negedge clk);
        sw_store = 1'b1;
        @(negedge clk);
        sw_store = 1'b0;
        exp_cnt++;
        @(negedge clk);
        sw_store = 1'b1;
        @(negedge clk);
        sw_store = 1'b0;
        while (op_busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R8 busy request dropped", {31'd0, op_busy}, 32'd0);
        chk("R10 count at limit", {29'd0, store_count}, exp_cnt);
        chk("R10 wear flag", {31'd0, wear_limit}, 32'd1);

        // R4 access ignored during busy; R10 saturation
        wr(17'd3, 8'h33);
        @(negedge clk);
        sw_store = 1'b1;
        @(negedge clk);
        sw_store = 1'b0;
        ce_n = 1'b0; we_n = 1'b0; addr = 17'd3; data_in = 8'hEE;
        #1;
        chk("R4 busy during op", {31'd0, op_busy}, 32'd1);
        @(negedge clk);
        we_n = 1'b1; oe_n = 1'b0;
        #1;
        chk("R4 read blocked", {31'd0, data_oe}, 32'd0);
        host_idle();
        while (op_busy) @(negedge clk);
        rd_chk("R4 write ignored", 17'd3, 8'h33);
        chk("R10 saturated", {29'd0, store_count}, END_LIM);

        // R9 nonvolatile survives reset, recall restores it
        wr(17'd5, 8'h77);
        run_op(1'b1, 1'b0, 1'b0, n, pl);
        wr(17'd5, 8'h11);
        rd_chk("R9 sram before reset", 17'd5, 8'h11);
        do_reset();
        while (op_busy) @(negedge clk);
        rd_chk("R9 recalled byte", 17'd5, 8'h77);
        run_op(1'b0, 1'b0, 1'b1, n, pl);
        chk("R9 recall clears writes", n, 0);

        finish_run();
    end
endmodule